// File: doc/BRIEF.md
# Accumulator Register Coprocessor

This block sits beside a processor core and executes custom instructions handed over on a valid/ready command port. Each command carries the full 32-bit instruction word and two 64-bit source operands. The block keeps a small bank of 64-bit accumulator registers. The funct7 field of the instruction picks one of four operations: set a register, return a register, fill a register from memory, or add to a register.

Only the return operation produces a result. The result goes out on a response channel and carries the destination register number taken from the instruction. The fill operation issues one 64-bit read on a simple valid/ready memory request port and takes the data from a memory response strobe. Software is expected to order its own stores with a fence before a fill, so the block tracks no outstanding stores. A busy output tells the core that a multi-cycle operation is still being handled.

Top module: `acc_coproc`

## Requirements
- R1: Only instructions whose bits [6:0] equal 7'b0001011 are executed. A command with any other opcode is accepted and ignored: no register changes, no response and no memory request.
- R2: funct7 (instruction bits [31:25]) selects the operation: 0 = set, 1 = return, 2 = fill from memory, 3 = add. Any other funct7 value is accepted and ignored.
- R3: The register index is rs2[1:0] for every operation, with 4 registers. Bits of rs2 above bit 1 are ignored.
- R4: Set writes rs1 into the indexed register on the accepting clock edge and sends no response.
- R5: Return raises rsp_valid in the cycle after acceptance, with rsp_data equal to the indexed register and rsp_rd equal to instruction bits [11:7]. Both stay stable until a cycle with rsp_ready high.
- R6: Add replaces the indexed register with its value plus rs1, modulo 2^64, and sends no response.
- R7: Fill raises mem_req_valid in the cycle after acceptance, with mem_req_addr equal to rs1. The request is held until mem_req_ready. The data on the first later mem_rsp_valid cycle is written to the indexed register, and no response is sent.
- R8: After a fill or return is accepted, busy is high and cmd_ready is low until that operation completes. Set and add finish on their accepting edge and leave busy low.
- R9: Reset clears every register to zero and deasserts busy, rsp_valid and mem_req_valid. cmd_ready is high after reset.
- R10: A command that follows a set, add or fill sees that operation's result. This holds even when the command is offered in the same cycle that the fill data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_inst | input | 32 | Instruction word |
| cmd_rs1 | input | 64 | First source operand: data, addend or byte address |
| cmd_rs2 | input | 64 | Second source operand: register index |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rd | output | 5 | Destination register number echoed from the instruction |
| rsp_data | output | 64 | Register value returned |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address to read |
| mem_rsp_valid | input | 1 | Read data is returning |
| mem_rsp_data | input | 64 | Returned 64-bit data |
| busy | output | 1 | An operation is in progress |

## Verification
The two events that can coincide are the return of fill data from memory and a new command offered on the command port. The bench starts a fill and lets the memory accept it. It then raises cmd_valid with an add to the same register, during the wait and also in the very cycle that mem_rsp_valid is driven. It judges the result in two ways: cmd_ready must stay low in that shared cycle and rise only afterwards, and a later return must show the loaded value plus the addend. This proves that the add was neither lost nor applied to the value from before the fill.

// File: rtl/acc_pkg.sv
package acc_pkg;

   localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

   typedef enum logic [1:0] {
      OP_PUT   = 2'd0,
      OP_GET   = 2'd1,
      OP_FETCH = 2'd2,
      OP_ACCUM = 2'd3
   } acc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MREQ  = 2'd1,
      ST_MWAIT = 2'd2,
      ST_RESP  = 2'd3
   } acc_state_e;

   typedef struct packed {
      logic    hit;
      acc_op_e op;
      logic [4:0] rd;
   } acc_dec_t;

endpackage

// File: rtl/acc_cmd_decode.sv
module acc_cmd_decode
   import acc_pkg::*;
(
   input  logic [31:0] inst,
   output acc_dec_t    dec
);
   logic unused_fields;
   assign unused_fields = ^inst[24:12];

   always_comb begin
      dec.rd  = inst[11:7];
      dec.op  = acc_op_e'(inst[26:25]);
      dec.hit = (inst[6:0] == OPC_CUSTOM0) && (inst[31:27] == 5'd0);
   end
endmodule

// File: rtl/acc_regbank.sv
module acc_regbank #(
   parameter int XLEN  = 64,
   parameter int NREGS = 4,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [XLEN-1:0]  wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [XLEN-1:0]  rdata
);
   logic [XLEN-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (we && (widx == IDX_W'(g)))
            regs[g] <= wdata;
      end
   end

   assign rdata = regs[ridx];
endmodule

// File: rtl/acc_coproc.sv
module acc_coproc
   import acc_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int NREGS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   output logic            cmd_ready,
   input  logic [31:0]     cmd_inst,
   input  logic [XLEN-1:0] cmd_rs1,
   input  logic [XLEN-1:0] cmd_rs2,
   output logic            rsp_valid,
   input  logic            rsp_ready,
   output logic [4:0]      rsp_rd,
   output logic [XLEN-1:0] rsp_data,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [XLEN-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [XLEN-1:0] mem_rsp_data,
   output logic            busy
);
   localparam int IDX_W = $clog2(NREGS);

   if (NREGS < 2 || (1 << IDX_W) != NREGS) begin : g_bad_nregs
      $error("NREGS must be a power of two and at least 2");
   end
   if (XLEN < 8) begin : g_bad_xlen
      $error("XLEN must be at least 8");
   end

   acc_dec_t        dec;
   acc_state_e      state_q;
   logic [IDX_W-1:0] cmd_idx, ld_idx_q, widx;
   logic            we, fire;
   logic [XLEN-1:0] wdata, rdata;
   logic unused_idx;

   assign unused_idx = ^cmd_rs2[XLEN-1:IDX_W];
   assign cmd_idx    = cmd_rs2[IDX_W-1:0];

   acc_cmd_decode u_dec (
      .inst (cmd_inst),
      .dec  (dec)
   );

   acc_regbank #(.XLEN(XLEN), .NREGS(NREGS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .widx  (widx),
      .wdata (wdata),
      .ridx  (cmd_idx),
      .rdata (rdata)
   );

   assign cmd_ready     = (state_q == ST_IDLE);
   assign fire          = cmd_valid && cmd_ready;
   assign busy          = (state_q != ST_IDLE);
   assign rsp_valid     = (state_q == ST_RESP);
   assign mem_req_valid = (state_q == ST_MREQ);

   always_comb begin
      we    = 1'b0;
      widx  = cmd_idx;
      wdata = cmd_rs1;
      if (fire && dec.hit) begin
         case (dec.op)
            OP_PUT:   we = 1'b1;
            OP_ACCUM: begin
               we    = 1'b1;
               wdata = rdata + cmd_rs1;
            end
            default:  we = 1'b0;
         endcase
      end
      if (state_q == ST_MWAIT && mem_rsp_valid) begin
         we    = 1'b1;
         widx  = ld_idx_q;
         wdata = mem_rsp_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         ld_idx_q     <= '0;
         mem_req_addr <= '0;
         rsp_rd       <= '0;
         rsp_data     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (fire && dec.hit) begin
                  if (dec.op == OP_GET) begin
                     rsp_data <= rdata;
                     rsp_rd   <= dec.rd;
                     state_q  <= ST_RESP;
                  end else if (dec.op == OP_FETCH) begin
                     mem_req_addr <= cmd_rs1;
                     ld_idx_q     <= cmd_idx;
                     state_q      <= ST_MREQ;
                  end
               end
            end
            ST_MREQ:  if (mem_req_ready) state_q <= ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
            ST_RESP:  if (rsp_ready)     state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // R5
   rsp_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.hit && dec.op == OP_GET) |=> (rsp_valid && rsp_rd == $past(cmd_inst[11:7])));

   // R5
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_rd)));

   // R7
   mreq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.hit && dec.op == OP_FETCH) |=> (mem_req_valid && mem_req_addr == $past(cmd_rs1)));

   // R7
   mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R4
   no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !(dec.hit && dec.op == OP_GET)) |=> !rsp_valid);

   // R8
   put_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.hit && (dec.op == OP_PUT || dec.op == OP_ACCUM)) |=> !busy);

   // R1
   foreign_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dec.hit) |=> (!busy && !mem_req_valid));
endmodule

// File: tb/tb_acc_coproc.sv
`timescale 1ns/1ps
module tb_acc_coproc;
   localparam logic [6:0] CUST0 = 7'b0001011;
   localparam logic [6:0] CUST1 = 7'b0101011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, rsp_ready = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
   logic [31:0] cmd_inst = '0;
   logic [63:0] cmd_rs1 = '0, cmd_rs2 = '0, mem_rsp_data = '0;
   logic cmd_ready, rsp_valid, mem_req_valid, busy;
   logic [4:0] rsp_rd;
   logic [63:0] rsp_data, mem_req_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   acc_coproc dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_inst(cmd_inst),
      .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rd(rsp_rd), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .busy(busy)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_cmd(input logic [6:0] opc, input logic [6:0] fn, input logic [4:0] rd,
                          input logic [63:0] a, input logic [63:0] b);
      cmd_inst  = {fn, 5'd12, 5'd11, (fn == 7'd1), 1'b1, 1'b1, rd, opc};
      cmd_rs1   = a;
      cmd_rs2   = b;
      cmd_valid = 1'b1;
   endtask

   task automatic issue(input logic [6:0] opc, input logic [6:0] fn, input logic [4:0] rd,
                        input logic [63:0] a, input logic [63:0] b);
      put_cmd(opc, fn, rd, a, b);
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_read(input string req, input logic [63:0] idx, input logic [4:0] rd,
                          input logic [63:0] exp, input int stall);
      issue(CUST0, 7'd1, rd, 64'd0, idx);
      chk({req, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
      chk({req, " rsp_rd"}, {59'd0, rsp_rd}, {59'd0, rd});
      chk({req, " rsp_data"}, rsp_data, exp);
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk("R5 held rsp_data", rsp_data, exp);
         chk("R8 busy during stalled response", {63'd0, busy}, 64'd1);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R5 rsp_valid drops", {63'd0, rsp_valid}, 64'd0);
   endtask

   task automatic do_load(input logic [63:0] idx, input logic [63:0] addr, input logic [63:0] data,
                          input int reqstall, input int lat);
      issue(CUST0, 7'd2, 5'd0, addr, idx);
      chk("R7 mem_req_valid", {63'd0, mem_req_valid}, 64'd1);
      chk("R7 mem_req_addr", mem_req_addr, addr);
      for (int s = 0; s < reqstall; s++) begin
         @(negedge clk);
         chk("R7 request held", mem_req_addr, addr);
         chk("R8 cmd_ready low in fill", {63'd0, cmd_ready}, 64'd0);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R7 single request", {63'd0, mem_req_valid}, 64'd0);
      chk("R8 busy waiting for data", {63'd0, busy}, 64'd1);
      for (int s = 0; s < lat; s++) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = data;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R8 busy clears after fill", {63'd0, busy}, 64'd0);
      chk("R7 no response for fill", {63'd0, rsp_valid}, 64'd0);
   endtask

   // table: funct, rs2 index, rs1 operand (or expected value for return)
   localparam int NV = 12;
   localparam logic [6:0]  VFN  [NV] = '{7'd0, 7'd3, 7'd1, 7'd0, 7'd3, 7'd1,
                                         7'd0, 7'd1, 7'd3, 7'd1, 7'd1, 7'd1};
   localparam logic [63:0] VIDX [NV] = '{64'd0, 64'd0, 64'd0, 64'd1, 64'd1, 64'd1,
                                         64'd6, 64'd2, 64'hFE, 64'd2, 64'd3, 64'h401};
   localparam logic [63:0] VVAL [NV] = '{64'd3, 64'd1, 64'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1,
                                         64'h1234, 64'h1234, 64'h10, 64'h1244, 64'd0, 64'd1};

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 busy", {63'd0, busy}, 64'd0);
      chk("R9 rsp_valid", {63'd0, rsp_valid}, 64'd0);
      chk("R9 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
      chk("R9 cmd_ready", {63'd0, cmd_ready}, 64'd1);
      for (int i = 0; i < 4; i++) do_read("R9 cleared reg", 64'(i), 5'(i), 64'd0, 0);

      // table walk: R4 R6 R3 R10
      for (int i = 0; i < NV; i++) begin
         if (VFN[i] == 7'd1) begin
            do_read("R6/R3 table return", VIDX[i], 5'(i + 3), VVAL[i], 0);
         end else begin
            issue(CUST0, VFN[i], 5'(i), VVAL[i], VIDX[i]);
            chk("R4 no response after set/add", {63'd0, rsp_valid}, 64'd0);
            chk("R8 set/add leaves busy low", {63'd0, busy}, 64'd0);
         end
      end

      // R5 stalled response
      do_read("R5 stalled return", 64'd2, 5'd31, 64'h1244, 3);

      // R7 fill then add 2
      do_load(64'd0, 64'h1000, 64'h3421, 2, 1);
      issue(CUST0, 7'd3, 5'd0, 64'd2, 64'd0);
      do_read("R7 fill plus add", 64'd0, 5'd9, 64'h3423, 0);

      // R1 foreign opcode ignored
      issue(CUST1, 7'd0, 5'd0, 64'd99, 64'd0);
      chk("R1 no response", {63'd0, rsp_valid}, 64'd0);
      chk("R1 no memory request", {63'd0, mem_req_valid}, 64'd0);
      issue(CUST1, 7'd1, 5'd4, 64'd0, 64'd0);
      chk("R1 foreign return gives nothing", {63'd0, rsp_valid}, 64'd0);
      do_read("R1 register unchanged", 64'd0, 5'd1, 64'h3423, 0);

      // R2 unknown funct7 ignored
      issue(CUST0, 7'd5, 5'd0, 64'd77, 64'd0);
      chk("R2 no response", {63'd0, rsp_valid}, 64'd0);
      chk("R2 no memory request", {63'd0, mem_req_valid}, 64'd0);
      issue(CUST0, 7'd64, 5'd0, 64'd77, 64'd0);
      do_read("R2 register unchanged", 64'd0, 5'd2, 64'h3423, 0);

      // R10 command offered while fill data returns
      issue(CUST0, 7'd2, 5'd0, 64'h2000, 64'd3);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      put_cmd(CUST0, 7'd3, 5'd0, 64'd5, 64'd3);
      chk("R8 cmd_ready low while waiting", {63'd0, cmd_ready}, 64'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 64'hDEAD_0000_0000_0010;
      #1;
      chk("R10 cmd_ready low in data cycle", {63'd0, cmd_ready}, 64'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk("R10 cmd_ready after data", {63'd0, cmd_ready}, 64'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      do_read("R10 add after fill", 64'd3, 5'd7, 64'hDEAD_0000_0000_0015, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule